// File: doc/BRIEF.md
# Dual-Channel Light Integration Sequencer

This block runs the timing for a pair of photodiode integrators that convert at the same time. For each window it counts comparator pulses per channel and converts the count into a result. The window length is a selectable whole multiple of a base cycle count. Each channel may take at most one count for every two oscillator periods. A fixed offset is subtracted from every count, and the result is clamped to the register width.

When a window closes, both results move into their output registers together, and a one-cycle strobe marks the update. The next window then starts on its own. The output registers change only at that update, so a reader sampling them between strobes always gets one coherent pair of values.

A select field picks one of three window lengths. Its fourth code holds the converter idle. Dropping the enable has the same idling effect, and in both cases the last published results stay visible.

Top module: `alsadc_seq`

## Requirements
- R1: While reset is asserted and after its release, both data outputs read 0 and the strobe is low until the first window completes.
- R2: With the enable high, a window lasts UNIT×MULT_SHORT cycles for select code 2'b00, UNIT×MULT_MID for 2'b01 and UNIT×MULT_LONG for 2'b10. The first strobe is seen that many cycles after the enable is raised.
- R3: A channel accepts a pulse only if it accepted none in the previous cycle. A channel pulsing in every cycle therefore collects half the window length.
- R4: The published value is the accepted count minus OFFSET (default 2), floored at 0.
- R5: The published value saturates at 2^DATA_W − 1.
- R6: Both channel results are published on the same clock edge, and the strobe is high for exactly one cycle per window.
- R7: Between strobes the data outputs do not change.
- R8: After a strobe the next window starts without any command and closes exactly one window length later.
- R9: Select code 2'b11 holds the converter idle. No strobe occurs and the data outputs keep their values.
- R10: Lowering the enable discards the partial window and keeps the published data. Raising it again starts a fresh, full-length window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable |
| itime_i | input | 2 | Window length select; 2'b11 idles the converter |
| cmp_pulse_i | input | 2 | Per-channel comparator pulses, bit 0 for channel 0 |
| ch0_data_o | output | DATA_W | Published channel 0 result |
| ch1_data_o | output | DATA_W | Published channel 1 result |
| done_o | output | 1 | One-cycle strobe marking a publish |

## Verification
Inputs are driven on falling edges. A window then spans exactly its nominal number of rising edges, so the strobe and the new data appear at the falling edge that comes window-length edges after the enable, or after the previous strobe. The bench counts falling edges up to the strobe, compares that count with the window length, and reads both results only at that point. Pulse trains run with periods that divide the window, so every count is known whatever the phase. Between strobes the bench samples the data on every falling edge to confirm it holds.

// File: rtl/alsadc_pkg.sv
package alsadc_pkg;

   typedef enum logic [1:0] {
      ITIME_SHORT  = 2'b00,
      ITIME_MID    = 2'b01,
      ITIME_LONG   = 2'b10,
      ITIME_MANUAL = 2'b11
   } itime_e;

   // Window length in oscillator cycles for a select code.
   function automatic int unsigned window_cycles(
      input logic [1:0]  sel,
      input int unsigned unit,
      input int unsigned m_short,
      input int unsigned m_mid,
      input int unsigned m_long
   );
      case (sel)
         2'b00:   return unit * m_short;
         2'b01:   return unit * m_mid;
         default: return unit * m_long;
      endcase
   endfunction

endpackage

// File: rtl/alsadc_window_timer.sv
module alsadc_window_timer
   import alsadc_pkg::*;
#(
   parameter int unsigned UNIT       = 918,
   parameter int unsigned MULT_SHORT = 11,
   parameter int unsigned MULT_MID   = 81,
   parameter int unsigned MULT_LONG  = 322
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active_i,
   input  logic [1:0] sel_i,
   output logic       win_end_o
);

   localparam int unsigned WIN_MAX = UNIT * MULT_LONG;
   localparam int unsigned CYC_W   = $clog2(WIN_MAX + 1);

   logic [CYC_W-1:0] cyc_q;
   logic [CYC_W-1:0] last_c;

   always_comb begin
      last_c    = CYC_W'(window_cycles(sel_i, UNIT, MULT_SHORT, MULT_MID, MULT_LONG) - 1);
      win_end_o = active_i && (cyc_q >= last_c);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
      end else if (!active_i || win_end_o) begin
         cyc_q <= '0;
      end else begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   // R2: the position counter never passes the longest window
   a_r2_window_bound : assert property (@(posedge clk) disable iff (!rst_n)
      cyc_q < CYC_W'(WIN_MAX));

endmodule

// File: rtl/alsadc_chan_acc.sv
module alsadc_chan_acc #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned OFFSET = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              win_end_i,
   input  logic              pulse_i,
   output logic [DATA_W-1:0] result_o
);

   localparam int unsigned RAW_W   = DATA_W + 1;
   localparam logic [RAW_W-1:0] SAT_RAW = RAW_W'((2 ** DATA_W) - 1 + OFFSET);
   localparam logic [RAW_W-1:0] OFF_RAW = RAW_W'(OFFSET);

   logic [RAW_W-1:0] raw_q, raw_next;
   logic             gate_q;
   logic             accept;

   always_comb begin
      accept   = active_i && pulse_i && !gate_q;
      raw_next = (accept && raw_q != SAT_RAW) ? raw_q + 1'b1 : raw_q;
      if (raw_next < OFF_RAW) result_o = '0;
      else                    result_o = DATA_W'(raw_next - OFF_RAW);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q  <= '0;
         gate_q <= 1'b0;
      end else if (!active_i || win_end_i) begin
         raw_q  <= '0;
         gate_q <= 1'b0;
      end else begin
         raw_q  <= raw_next;
         gate_q <= accept;
      end
   end

   // R3: two increments never happen on back-to-back edges
   a_r3_rate_cap : assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q == $past(raw_q) + 1'b1) |=> (raw_q != $past(raw_q) + 1'b1));

   // R5: the running count stays within the saturated range
   a_r5_saturate : assert property (@(posedge clk) disable iff (!rst_n)
      raw_q <= SAT_RAW);

endmodule

// File: rtl/alsadc_result_buf.sv
module alsadc_result_buf #(
   parameter int unsigned NCH    = 2,
   parameter int unsigned DATA_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load_i,
   input  logic [NCH-1:0][DATA_W-1:0] res_i,
   output logic [NCH-1:0][DATA_W-1:0] data_o,
   output logic                       done_o
);

   logic [NCH-1:0][DATA_W-1:0] data_q;
   logic                       done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= load_i;
         if (load_i) data_q <= res_i;
      end
   end

   assign data_o = data_q;
   assign done_o = done_q;

   // R7: published data only moves on a load
   a_r7_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(data_q));

endmodule

// File: rtl/alsadc_seq.sv
module alsadc_seq
   import alsadc_pkg::*;
#(
   parameter int unsigned UNIT       = 918,
   parameter int unsigned MULT_SHORT = 11,
   parameter int unsigned MULT_MID   = 81,
   parameter int unsigned MULT_LONG  = 322,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned OFFSET     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [1:0]        itime_i,
   input  logic [1:0]        cmp_pulse_i,
   output logic [DATA_W-1:0] ch0_data_o,
   output logic [DATA_W-1:0] ch1_data_o,
   output logic              done_o
);

   localparam int unsigned NCH = 2;

   if (UNIT < 2 || (UNIT % 2) != 0) begin : g_bad_unit
      $error("UNIT must be even and at least 2");
   end
   if (MULT_SHORT == 0 || MULT_SHORT > MULT_MID || MULT_MID > MULT_LONG) begin : g_bad_mult
      $error("window multiples must be nonzero and ascending");
   end
   if (DATA_W < 4 || DATA_W > 24) begin : g_bad_width
      $error("DATA_W out of supported range");
   end
   if (OFFSET > 15) begin : g_bad_offset
      $error("OFFSET out of supported range");
   end

   logic                       active;
   logic                       win_end;
   logic [NCH-1:0][DATA_W-1:0] res;
   logic [NCH-1:0][DATA_W-1:0] data;

   assign active = en_i && (itime_i != ITIME_MANUAL);

   alsadc_window_timer #(
      .UNIT       (UNIT),
      .MULT_SHORT (MULT_SHORT),
      .MULT_MID   (MULT_MID),
      .MULT_LONG  (MULT_LONG)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .active_i  (active),
      .sel_i     (itime_i),
      .win_end_o (win_end)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      alsadc_chan_acc #(
         .DATA_W (DATA_W),
         .OFFSET (OFFSET)
      ) u_acc (
         .clk       (clk),
         .rst_n     (rst_n),
         .active_i  (active),
         .win_end_i (win_end),
         .pulse_i   (cmp_pulse_i[c]),
         .result_o  (res[c])
      );
   end

   alsadc_result_buf #(
      .NCH    (NCH),
      .DATA_W (DATA_W)
   ) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (win_end),
      .res_i  (res),
      .data_o (data),
      .done_o (done_o)
   );

   assign ch0_data_o = data[0];
   assign ch1_data_o = data[1];

   // R6: the strobe follows the window end and lasts one cycle
   a_r6_done_follows_end : assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> done_o);
   a_r6_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9 / R10: an idle converter publishes nothing
   a_r9_idle_no_done : assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !done_o);

endmodule

// File: tb/alsadc_seq_tb.sv
`timescale 1ns/1ps
module alsadc_seq_tb;

   localparam int UNIT  = 8;
   localparam int W     = 8;
   localparam int WIN_S = UNIT * 11;
   localparam int WIN_M = UNIT * 81;
   localparam int WIN_L = UNIT * 322;
   localparam int MAXV  = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic [1:0]   itime = 2'b00;
   logic [1:0]   pulse = 2'b00;
   logic [W-1:0] ch0, ch1;
   logic         done;

   int checks = 0;
   int fails  = 0;
   int div0 = 0;
   int div1 = 0;
   int tick = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   alsadc_seq #(.UNIT(UNIT), .DATA_W(W)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en),
      .itime_i     (itime),
      .cmp_pulse_i (pulse),
      .ch0_data_o  (ch0),
      .ch1_data_o  (ch1),
      .done_o      (done)
   );

   // Pulse trains whose periods divide the window give phase-free counts.
   always @(negedge clk) begin
      tick     <= tick + 1;
      pulse[0] <= (div0 != 0) && (tick % (div0 == 0 ? 1 : div0) == 0);
      pulse[1] <= (div1 != 0) && (tick % (div1 == 0 ? 1 : div1) == 0);
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Counts falling edges until the strobe; data must hold meanwhile (R7).
   task automatic wait_done(output int n);
      logic [W-1:0] p0, p1;
      bit moved;
      n = 0; moved = 0; p0 = ch0; p1 = ch1;
      do begin
         @(negedge clk);
         n++;
         if (!done && (ch0 != p0 || ch1 != p1)) moved = 1;
      end while (!done && n < 20000);
      check(!moved, "R7", int'(moved), 0);
   endtask

   task automatic start(input logic [1:0] sel, input int d0, input int d1);
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      itime = sel; div0 = d0; div1 = d1;
      en = 1'b1;
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check(ch0 == 0 && ch1 == 0, "R1", int'(ch0) + int'(ch1), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(done == 1'b0, "R1", int'(done), 0);
      check(ch0 == 0 && ch1 == 0, "R1", int'(ch0) + int'(ch1), 0);
   endtask

   task automatic t_short;
      int n;
      start(2'b00, 1, 4);
      wait_done(n);
      check(n == WIN_S, "R2", n, WIN_S);
      check(ch0 == WIN_S / 2 - 2, "R3", int'(ch0), WIN_S / 2 - 2);
      check(ch1 == WIN_S / 4 - 2, "R6", int'(ch1), WIN_S / 4 - 2);
      @(negedge clk);
      check(done == 1'b0, "R6", int'(done), 0);
      wait_done(n);
      check(n == WIN_S - 1, "R8", n, WIN_S - 1);
      check(ch0 == WIN_S / 2 - 2, "R8", int'(ch0), WIN_S / 2 - 2);
   endtask

   task automatic t_few;
      int n;
      start(2'b00, 22, 44);
      wait_done(n);
      check(n == WIN_S, "R2", n, WIN_S);
      check(ch0 == 2, "R4", int'(ch0), 2);
      check(ch1 == 0, "R4", int'(ch1), 0);
   endtask

   task automatic t_mid;
      int n;
      start(2'b01, 1, 8);
      wait_done(n);
      check(n == WIN_M, "R2", n, WIN_M);
      check(ch0 == MAXV, "R5", int'(ch0), MAXV);
      check(ch1 == WIN_M / 8 - 2, "R4", int'(ch1), WIN_M / 8 - 2);
   endtask

   task automatic t_long;
      int n;
      start(2'b10, 1, 0);
      wait_done(n);
      check(n == WIN_L, "R2", n, WIN_L);
      check(ch0 == MAXV, "R5", int'(ch0), MAXV);
      check(ch1 == 0, "R4", int'(ch1), 0);
   endtask

   task automatic t_manual;
      logic [W-1:0] p0, p1;
      bit seen;
      seen = 0; p0 = ch0; p1 = ch1;
      start(2'b11, 1, 2);
      repeat (3 * WIN_S) begin
         @(negedge clk);
         if (done) seen = 1;
      end
      check(!seen, "R9", int'(seen), 0);
      check(ch0 == p0 && ch1 == p1, "R9", int'(ch0), int'(p0));
   endtask

   task automatic t_disable;
      int n;
      logic [W-1:0] p0, p1;
      bit seen;
      start(2'b00, 1, 4);
      wait_done(n);
      p0 = ch0; p1 = ch1;
      repeat (50) @(negedge clk);
      en = 1'b0;
      seen = 0;
      repeat (WIN_S) begin
         @(negedge clk);
         if (done) seen = 1;
      end
      check(!seen, "R10", int'(seen), 0);
      check(ch0 == p0 && ch1 == p1, "R10", int'(ch1), int'(p1));
      div0 = 2; div1 = 1;
      en = 1'b1;
      wait_done(n);
      check(n == WIN_S, "R10", n, WIN_S);
      check(ch0 == WIN_S / 2 - 2, "R10", int'(ch0), WIN_S / 2 - 2);
      check(ch1 == WIN_S / 2 - 2, "R10", int'(ch1), WIN_S / 2 - 2);
   endtask

   initial begin
      t_reset();
      t_short();
      t_few();
      t_mid();
      t_long();
      t_manual();
      t_disable();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule